// File: doc/BRIEF.md
# Dual-Host Board Control Register File

This block is a small bank of byte-wide control and status registers shared by two hosts. Host A is the narrow-address host and host B is the board processor. Each host has its own strobes, its own 5-bit register address and its own write data. The two hosts reach the same registers, but each uses its own address map. Register state drives the board-wide control lines: the board mode, the processor hard reset, the bus priority bits, the FPGA configuration controls, the device selects with the upper page address, and two interprocessor interrupt lines.

Reads are combinational. Read data is zero unless the host's read strobe is high. A read of a write-only register returns zero, and so does a read of an unmapped address. Writes take effect on the next rising clock edge.

Top module: `dual_host_regfile`

## Requirements
- R1: After reset the mode bits are 00 (Idle) and the processor reset request is set, so proc_hreset is 1. Both interrupt lines, all configuration controls and all page outputs are 0.
- R2: Host A and host B reach the same registers at their own addresses. For the general purpose register these are 10001 for A and 10011 for B. The other addresses are: status 00000/00011, B-to-A flag 01010/01011, A-to-B flag 11011/11011, priority 00100/00111, helper 10101/10111, accelerator store 01110/01111, page 11111/11111.
- R3: The status byte has these bits: bit0 = priority bit3 (mode_cfg), bit1 = priority bit4 (mode_start), bit2 = fa_done, bit3 = fa_init_n, bit4 = fb_done, bit5 = fb_init_n, bit6 = helper bit0 (configuration clock enable), bit7 = cfg_sync.
- R4: Reads of the priority, helper and page registers return 0, and so do reads of unmapped addresses. A write to the status address changes nothing.
- R5: Priority register bits [2:0] drive prio[2:0]. Bit3 is mode_cfg and bit4 is mode_start. The mode encoding {start,cfg} is 00 Idle, 01 Write, 10 Config, 11 Normal.
- R6: proc_hreset is 1 whenever mode_start is 0, that is in Idle or Write. In Config or Normal it follows the reset request bit, which is priority bit5.
- R7: The helper register bits drive cfg_clk_en (bit0), cfg_start_a (bit1), cfg_start_b (bit2) and cfg_master (bit5). Bit3 and bit4 reach lut_sel_a and lut_sel_b only while page_drive is 1.
- R8: In each flag register only bit0 is used. The requesting side sets the flag by writing bit0 = 1, and the servicing side clears it by writing bit0 = 0. The other writes to a flag have no effect. The flag level is the interrupt line: B sets irq_to_a and A clears it, while A sets irq_to_b and B clears it. A read returns the flag in bit0.
- R9: Page register bits drive fpga_sel_a (bit1), fpga_sel_b (bit2), sram_sel (bit3) and page_addr[3:0] (bits 7:4). Bit0 drives nothing.
- R10: The accelerator store samples accel_irq_a into bit0 and accel_irq_b into bit1 on every clock. A read shows this sample one cycle after the inputs change. Writes to the store are ignored.
- R11: When both hosts write the same shared register in the same cycle, host A's data is kept.
- R12: rdata_a and rdata_b are 0 whenever the matching read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr | input | 1 | Host A write strobe |
| a_rd | input | 1 | Host A read strobe |
| a_addr | input | 5 | Host A register address |
| a_wdata | input | 8 | Host A write data |
| b_wr | input | 1 | Host B write strobe |
| b_rd | input | 1 | Host B read strobe |
| b_addr | input | 5 | Host B register address |
| b_wdata | input | 8 | Host B write data |
| fa_done | input | 1 | FPGA A configuration done |
| fa_init_n | input | 1 | FPGA A init line |
| fb_done | input | 1 | FPGA B configuration done |
| fb_init_n | input | 1 | FPGA B init line |
| cfg_sync | input | 1 | Configuration sync clock |
| accel_irq_a | input | 1 | FPGA A interrupt request |
| accel_irq_b | input | 1 | FPGA B interrupt request |
| page_drive | input | 1 | Page register is driving the bus |
| rdata_a | output | 8 | Host A read data |
| rdata_b | output | 8 | Host B read data |
| prio | output | 3 | Bus priority bits |
| mode_cfg | output | 1 | Configuration mode bit |
| mode_start | output | 1 | Start mode bit |
| proc_hreset | output | 1 | Processor hard reset |
| cfg_clk_en | output | 1 | Configuration clock enable |
| cfg_start_a | output | 1 | FPGA A configuration start/program |
| cfg_start_b | output | 1 | FPGA B configuration start/program |
| cfg_master | output | 1 | Configuration master select |
| lut_sel_a | output | 1 | FPGA A lookup-table select |
| lut_sel_b | output | 1 | FPGA B lookup-table select |
| fpga_sel_a | output | 1 | FPGA A select |
| fpga_sel_b | output | 1 | FPGA B select |
| sram_sel | output | 1 | Shared SRAM select |
| page_addr | output | 4 | Upper address bits 16..19 |
| irq_to_a | output | 1 | Interrupt to host A |
| irq_to_b | output | 1 | Interrupt to host B |

## Verification
The properties assume that the hosts change strobes, addresses and data only between clock edges. They also assume that reset is held low for at least one clock at start-up. The stimulus meets both assumptions because every input is driven at the falling edge and reset is held for several cycles. The flag and write-only properties assume host A's address is stable while its strobes are high. Every bench task holds the address for the whole strobe cycle.

// File: rtl/dual_host_regfile.sv
module dual_host_regfile (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_wr,
  input  logic       a_rd,
  input  logic [4:0] a_addr,
  input  logic [7:0] a_wdata,
  input  logic       b_wr,
  input  logic       b_rd,
  input  logic [4:0] b_addr,
  input  logic [7:0] b_wdata,
  input  logic       fa_done,
  input  logic       fa_init_n,
  input  logic       fb_done,
  input  logic       fb_init_n,
  input  logic       cfg_sync,
  input  logic       accel_irq_a,
  input  logic       accel_irq_b,
  input  logic       page_drive,
  output logic [7:0] rdata_a,
  output logic [7:0] rdata_b,
  output logic [2:0] prio,
  output logic       mode_cfg,
  output logic       mode_start,
  output logic       proc_hreset,
  output logic       cfg_clk_en,
  output logic       cfg_start_a,
  output logic       cfg_start_b,
  output logic       cfg_master,
  output logic       lut_sel_a,
  output logic       lut_sel_b,
  output logic       fpga_sel_a,
  output logic       fpga_sel_b,
  output logic       sram_sel,
  output logic [3:0] page_addr,
  output logic       irq_to_a,
  output logic       irq_to_b
);
  localparam logic [4:0] A_STS = 5'b00000, B_STS = 5'b00011;
  localparam logic [4:0] A_GP  = 5'b10001, B_GP  = 5'b10011;
  localparam logic [4:0] A_FBA = 5'b01010, B_FBA = 5'b01011;
  localparam logic [4:0] A_FAB = 5'b11011, B_FAB = 5'b11011;
  localparam logic [4:0] A_PRI = 5'b00100, B_PRI = 5'b00111;
  localparam logic [4:0] A_HLP = 5'b10101, B_HLP = 5'b10111;
  localparam logic [4:0] A_ACC = 5'b01110, B_ACC = 5'b01111;
  localparam logic [4:0] A_PG  = 5'b11111, B_PG  = 5'b11111;

  logic [7:0] gp_q;
  logic [5:0] pri_q;
  logic [5:0] hlp_q;
  logic [7:1] pg_q;
  logic [1:0] acc_q;
  logic       fba_q, fab_q;
  logic [7:0] sts;

  wire aw_gp  = a_wr && a_addr == A_GP;
  wire bw_gp  = b_wr && b_addr == B_GP;
  wire aw_pri = a_wr && a_addr == A_PRI;
  wire bw_pri = b_wr && b_addr == B_PRI;
  wire aw_hlp = a_wr && a_addr == A_HLP;
  wire bw_hlp = b_wr && b_addr == B_HLP;
  wire aw_pg  = a_wr && a_addr == A_PG;
  wire bw_pg  = b_wr && b_addr == B_PG;

  wire fba_set = b_wr && b_addr == B_FBA &&  b_wdata[0];
  wire fba_clr = a_wr && a_addr == A_FBA && !a_wdata[0];
  wire fab_set = a_wr && a_addr == A_FAB &&  a_wdata[0];
  wire fab_clr = b_wr && b_addr == B_FAB && !b_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gp_q  <= '0;
      pri_q <= 6'b100000;
      hlp_q <= '0;
      pg_q  <= '0;
      acc_q <= '0;
      fba_q <= 1'b0;
      fab_q <= 1'b0;
    end else begin
      acc_q <= {accel_irq_b, accel_irq_a};
      if (aw_gp)       gp_q  <= a_wdata;
      else if (bw_gp)  gp_q  <= b_wdata;
      if (aw_pri)      pri_q <= a_wdata[5:0];
      else if (bw_pri) pri_q <= b_wdata[5:0];
      if (aw_hlp)      hlp_q <= a_wdata[5:0];
      else if (bw_hlp) hlp_q <= b_wdata[5:0];
      if (aw_pg)       pg_q  <= a_wdata[7:1];
      else if (bw_pg)  pg_q  <= b_wdata[7:1];
      if (fba_set)      fba_q <= 1'b1;
      else if (fba_clr) fba_q <= 1'b0;
      if (fab_set)      fab_q <= 1'b1;
      else if (fab_clr) fab_q <= 1'b0;
    end
  end

  assign sts = {cfg_sync, hlp_q[0], fb_init_n, fb_done, fa_init_n, fa_done,
                pri_q[4], pri_q[3]};

  always_comb begin
    rdata_a = '0;
    if (a_rd)
      case (a_addr)
        A_STS:   rdata_a = sts;
        A_GP:    rdata_a = gp_q;
        A_FBA:   rdata_a = {7'b0, fba_q};
        A_FAB:   rdata_a = {7'b0, fab_q};
        A_ACC:   rdata_a = {6'b0, acc_q};
        default: rdata_a = '0;
      endcase
  end

  always_comb begin
    rdata_b = '0;
    if (b_rd)
      case (b_addr)
        B_STS:   rdata_b = sts;
        B_GP:    rdata_b = gp_q;
        B_FBA:   rdata_b = {7'b0, fba_q};
        B_FAB:   rdata_b = {7'b0, fab_q};
        B_ACC:   rdata_b = {6'b0, acc_q};
        default: rdata_b = '0;
      endcase
  end

  assign prio        = pri_q[2:0];
  assign mode_cfg    = pri_q[3];
  assign mode_start  = pri_q[4];
  assign proc_hreset = !pri_q[4] || pri_q[5];
  assign cfg_clk_en  = hlp_q[0];
  assign cfg_start_a = hlp_q[1];
  assign cfg_start_b = hlp_q[2];
  assign lut_sel_a   = hlp_q[3] && page_drive;
  assign lut_sel_b   = hlp_q[4] && page_drive;
  assign cfg_master  = hlp_q[5];
  assign fpga_sel_a  = pg_q[1];
  assign fpga_sel_b  = pg_q[2];
  assign sram_sel    = pg_q[3];
  assign page_addr   = pg_q[7:4];
  assign irq_to_a    = fba_q;
  assign irq_to_b    = fab_q;
endmodule

// File: rtl/dual_host_regfile_chk.sv
module dual_host_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       a_wr,
  input logic       a_rd,
  input logic [4:0] a_addr,
  input logic [7:0] a_wdata,
  input logic       page_drive,
  input logic [7:0] rdata_a,
  input logic       mode_cfg,
  input logic       mode_start,
  input logic       proc_hreset,
  input logic       lut_sel_a,
  input logic       lut_sel_b,
  input logic       irq_to_b
);
  AST_IDLE_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_start |-> proc_hreset); // R6
  AST_LUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !page_drive |-> (!lut_sel_a && !lut_sel_b)); // R7
  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd && a_addr == 5'b00000) |-> rdata_a[1:0] == {mode_start, mode_cfg}); // R3
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd && a_addr == 5'b00100) |-> rdata_a == 8'h00); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && a_addr == 5'b11011 && a_wdata[0]) |=> irq_to_b); // R8
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd |-> rdata_a == 8'h00); // R12
endmodule

bind dual_host_regfile dual_host_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr),
  .a_wdata(a_wdata), .page_drive(page_drive), .rdata_a(rdata_a),
  .mode_cfg(mode_cfg), .mode_start(mode_start), .proc_hreset(proc_hreset),
  .lut_sel_a(lut_sel_a), .lut_sel_b(lut_sel_b), .irq_to_b(irq_to_b));

// File: tb/tb_dual_host_regfile.sv
module tb_dual_host_regfile;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [4:0] a_addr = 0, b_addr = 0;
  logic [7:0] a_wdata = 0, b_wdata = 0;
  logic fa_done = 1, fa_init_n = 0, fb_done = 0, fb_init_n = 1, cfg_sync = 1;
  logic accel_irq_a = 0, accel_irq_b = 0, page_drive = 0;
  logic [7:0] rdata_a, rdata_b;
  logic [2:0] prio;
  logic mode_cfg, mode_start, proc_hreset, cfg_clk_en, cfg_start_a, cfg_start_b;
  logic cfg_master, lut_sel_a, lut_sel_b, fpga_sel_a, fpga_sel_b, sram_sel;
  logic [3:0] page_addr;
  logic irq_to_a, irq_to_b;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_host_regfile dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit host_b, logic [4:0] ad, logic [7:0] d);
    @(negedge clk);
    if (host_b) begin b_wr = 1; b_addr = ad; b_wdata = d; end
    else begin a_wr = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic rd(bit host_b, logic [4:0] ad, logic [7:0] exp, string req);
    @(negedge clk);
    if (host_b) begin b_rd = 1; b_addr = ad; end
    else begin a_rd = 1; a_addr = ad; end
    #1;
    check(req, host_b ? rdata_b : rdata_a, exp);
    @(negedge clk);
    a_rd = 0; b_rd = 0;
  endtask

  task automatic t_reset;
    check("R1 mode", {mode_start, mode_cfg}, 2'b00);
    check("R1 hreset", proc_hreset, 1'b1);
    check("R1 irq", {irq_to_a, irq_to_b}, 2'b00);
    check("R1 cfg", {cfg_clk_en, cfg_start_a, cfg_start_b, cfg_master}, 4'h0);
    check("R1 page", {fpga_sel_a, fpga_sel_b, sram_sel, page_addr}, 7'h0);
    rd(0, 5'b00000, 8'hA4, "R3 status after reset");
  endtask

  task automatic t_gp;
    wr(0, 5'b10001, 8'h5A);
    rd(1, 5'b10011, 8'h5A, "R2 gp A->B");
    wr(1, 5'b10011, 8'hC3);
    rd(0, 5'b10001, 8'hC3, "R2 gp B->A");
  endtask

  task automatic t_prio;
    wr(0, 5'b00100, 8'h0D);
    check("R5 prio", prio, 3'b101);
    check("R5 mode write", {mode_start, mode_cfg}, 2'b01);
    check("R6 hreset in write", proc_hreset, 1'b1);
    rd(1, 5'b00011, 8'hA5, "R3 status mirror");
    rd(0, 5'b00100, 8'h00, "R4 prio write-only");
    wr(1, 5'b00111, 8'h18);
    check("R6 normal release", proc_hreset, 1'b0);
    check("R5 prio cleared", prio, 3'b000);
    wr(1, 5'b00111, 8'h38);
    check("R6 request holds", proc_hreset, 1'b1);
    wr(0, 5'b00100, 8'h10);
    check("R6 config release", proc_hreset, 1'b0);
    wr(0, 5'b00100, 8'h00);
    check("R6 idle holds", proc_hreset, 1'b1);
  endtask

  task automatic t_status_wr;
    wr(0, 5'b00000, 8'hFF);
    wr(1, 5'b00011, 8'hFF);
    rd(0, 5'b00000, 8'hA4, "R4 status write ignored");
    check("R4 mode unchanged", {mode_start, mode_cfg}, 2'b00);
    rd(0, 5'b00001, 8'h00, "R4 unmapped read");
  endtask

  task automatic t_helper;
    page_drive = 0;
    wr(0, 5'b10101, 8'h3F);
    check("R7 helper outs", {cfg_clk_en, cfg_start_a, cfg_start_b, cfg_master}, 4'hF);
    check("R7 lut gated", {lut_sel_a, lut_sel_b}, 2'b00);
    page_drive = 1; #1;
    check("R7 lut driven", {lut_sel_a, lut_sel_b}, 2'b11);
    rd(1, 5'b00011, 8'hE4, "R3 clk enable bit");
    rd(0, 5'b10101, 8'h00, "R4 helper write-only");
    wr(1, 5'b10111, 8'h04);
    check("R7 start a low b high", {cfg_start_a, cfg_start_b}, 2'b01);
    page_drive = 0;
  endtask

  task automatic t_page;
    wr(0, 5'b11111, 8'hA6);
    check("R9 page A", {fpga_sel_a, fpga_sel_b, sram_sel, page_addr}, {3'b110, 4'hA});
    wr(1, 5'b11111, 8'h59);
    check("R9 page B", {fpga_sel_a, fpga_sel_b, sram_sel, page_addr}, {3'b001, 4'h5});
    rd(1, 5'b11111, 8'h00, "R4 page write-only");
  endtask

  task automatic t_flags;
    wr(1, 5'b01011, 8'h01);
    check("R8 B sets irq_to_a", irq_to_a, 1'b1);
    rd(0, 5'b01010, 8'h01, "R8 flag read");
    wr(0, 5'b01010, 8'h01);
    check("R8 servicer set ignored", irq_to_a, 1'b1);
    wr(1, 5'b01011, 8'h00);
    check("R8 requester clear ignored", irq_to_a, 1'b1);
    wr(0, 5'b01010, 8'h00);
    check("R8 A clears", irq_to_a, 1'b0);
    wr(0, 5'b11011, 8'h01);
    check("R8 A sets irq_to_b", irq_to_b, 1'b1);
    rd(1, 5'b11011, 8'h01, "R8 flag read B");
    wr(1, 5'b11011, 8'h00);
    check("R8 B clears", irq_to_b, 1'b0);
  endtask

  task automatic t_acc;
    @(negedge clk); accel_irq_a = 1; accel_irq_b = 0;
    rd(0, 5'b01110, 8'h01, "R10 store A");
    @(negedge clk); accel_irq_a = 0; accel_irq_b = 1;
    rd(1, 5'b01111, 8'h02, "R10 store B");
    wr(0, 5'b01110, 8'hFF);
    rd(0, 5'b01110, 8'h02, "R10 write ignored");
    accel_irq_b = 0;
  endtask

  task automatic t_collide;
    @(negedge clk);
    a_wr = 1; a_addr = 5'b10001; a_wdata = 8'h11;
    b_wr = 1; b_addr = 5'b10011; b_wdata = 8'h22;
    @(negedge clk); a_wr = 0; b_wr = 0;
    rd(1, 5'b10011, 8'h11, "R11 host A wins");
  endtask

  task automatic t_rdgate;
    @(negedge clk);
    a_addr = 5'b10001; b_addr = 5'b10011; #1;
    check("R12 rdata_a idle", rdata_a, 8'h00);
    check("R12 rdata_b idle", rdata_b, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_gp();
    t_prio();
    t_status_wr();
    t_helper();
    t_page();
    t_flags();
    t_acc();
    t_collide();
    t_rdgate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule